// File: doc/BRIEF.md
# Link Error Status Register

This block collects the error events reported by a full-speed serial bus link layer. Each error source has its own sticky status bit. The bit goes high in the cycle after its one-cycle event pulse arrives, which may be in the middle of a packet rather than at the end of a token. Software reads the status byte over a simple byte-addressed register port and clears any bit by writing a one to that bit.

A second byte, the enable mask, selects which latched bits feed a single registered summary flag. The summary flag goes to the system interrupt logic. Detecting the errors and the wider interrupt controller are outside this block. It only latches, clears, masks and reduces.

Top module: `link_err_status`

## Requirements
- R1: After reset the status byte and the enable byte both read 0x00, and the summary flag is low.
- R2: A one-cycle pulse on an event input sets the matching status bit at the next clock edge. The bit then stays set until it is cleared by software.
- R3: Status bit positions are fixed as follows: 0 packet-identifier check, 1 token CRC5, 2 data CRC16, 3 data field not a whole number of bytes, 4 bus turnaround timeout, 5 DMA or buffer overrun, 7 bit-stuff violation. Bit 6 is reserved: it always reads 0, and a pulse on event input 6 has no effect.
- R4: A write to the status address clears each status bit whose write-data bit is one. Bits written with zero keep their value.
- R5: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The enable byte is a plain read/write register at its own address. Bit 6 of the enable byte always reads 0.
- R7: The summary flag equals the OR over all bits of (status AND enable), registered one cycle after the status and enable bytes. A set bit whose enable is clear does not raise the flag.
- R8: A status read returns the latched bits whatever the enable byte holds.
- R9: Several event pulses in the same cycle all latch.
- R10: A read from any address other than the two mapped ones returns 0x00. A write to such an address changes neither register.
- R11: A write to the enable address leaves the status byte unchanged, and a write to the status address leaves the enable byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register (combinational) |
| errEvent | input | 8 | One-cycle error pulses, one per status bit position |
| errSummary | output | 1 | Registered masked OR of the status bits |

## Verification
A status bit that is wrongly dropped or wrongly set shows up in the very next read of the status address. It also reaches the summary flag one cycle later, provided its enable is set. The bench therefore reads the status byte right after each pulse or clear. It samples the summary flag twice: once in the cycle before the update is due, to prove the register stage is there, and once in the cycle when it is due. This timing also exposes a wrong priority between setting and clearing, a reserved bit that has come alive, and address decode that leaks across registers.

// File: rtl/link_err_status_pkg.sv
package link_err_status_pkg;
  localparam int REG_W    = 8;
  localparam int RSVD_POS = 6;

  localparam int POS_PID      = 0;
  localparam int POS_CRC5     = 1;
  localparam int POS_CRC16    = 2;
  localparam int POS_FRAG     = 3;
  localparam int POS_TURN_TO  = 4;
  localparam int POS_DMA      = 5;
  localparam int POS_STUFF    = 7;

  localparam logic [REG_W-1:0] LIVE_MASK = ~(REG_W'(1) << RSVD_POS);

  typedef struct packed {
    logic statusWr;
    logic enableWr;
    logic statusRd;
    logic enableRd;
  } regStrobe_t;
endpackage

// File: rtl/link_err_status_ctrl.sv
module link_err_status_ctrl
  import link_err_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h04
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);
  logic hitStatus;
  logic hitEnable;

  always_comb begin
    hitStatus       = (busAddr == STATUS_ADDR);
    hitEnable       = (busAddr == ENABLE_ADDR);
    strobe.statusRd = hitStatus;
    strobe.enableRd = hitEnable;
    strobe.statusWr = hitStatus & busWrEn;
    strobe.enableWr = hitEnable & busWrEn;
  end

  always_comb begin
    assert_onehot_strobe_R10: assert ($onehot0({strobe.statusRd, strobe.enableRd}));
  end
endmodule

// File: rtl/link_err_status_dp.sv
module link_err_status_dp
  import link_err_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] errEvent,
  output logic [REG_W-1:0] rdData,
  output logic             summary
);
  logic [REG_W-1:0] statusQ, statusNext;
  logic [REG_W-1:0] enableQ, enableNext;
  logic [REG_W-1:0] clrMask;
  logic             summaryQ;

  assign clrMask = strobe.statusWr ? wrData : '0;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == RSVD_POS) begin : g_rsvd
      assign statusNext[i] = 1'b0;
      assign enableNext[i] = 1'b0;
    end else begin : g_live
      // set has priority over write-one-to-clear (R5)
      assign statusNext[i] = errEvent[i] | (statusQ[i] & ~clrMask[i]);
      assign enableNext[i] = strobe.enableWr ? wrData[i] : enableQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      summaryQ <= 1'b0;
    end else begin
      statusQ  <= statusNext;
      enableQ  <= enableNext;
      summaryQ <= |(statusQ & enableQ);
    end
  end

  always_comb begin
    if (strobe.statusRd)      rdData = statusQ;
    else if (strobe.enableRd) rdData = enableQ;
    else                      rdData = '0;
  end

  assign summary = summaryQ;

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[RSVD_POS] == 1'b0) && (enableQ[RSVD_POS] == 1'b0));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    |(errEvent & LIVE_MASK) |=> ((statusQ & $past(errEvent & LIVE_MASK)) == $past(errEvent & LIVE_MASK)));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statusQ) & ~$past(clrMask) & ~statusQ) == '0));

  assert_summary_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (summaryQ == |($past(statusQ) & $past(enableQ))));

  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enableWr |=> $stable(enableQ));
endmodule

// File: rtl/link_err_status.sv
module link_err_status
  import link_err_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic [REG_W-1:0]  errEvent,
  output logic              errSummary
);
  regStrobe_t strobe;

  link_err_status_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  link_err_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .errEvent(errEvent), .rdData(busRdData), .summary(errSummary)
  );
endmodule

// File: tb/link_err_status_test.sv
module link_err_status_test;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_EN   = 8'h04;
  localparam logic [7:0] A_NONE = 8'h08;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] errEvent = '0;
  logic       errSummary;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_err_status uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .errEvent(errEvent),
    .errSummary(errSummary)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulse(logic [7:0] ev);
    @(negedge clk);
    errEvent = ev;
    @(negedge clk);
    errEvent = '0;
  endtask

  task automatic clean();
    wr(A_EN, 8'h00);
    wr(A_STAT, 8'hFF);
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    rd(A_STAT, d); check("R1 status", d, 8'h00);
    rd(A_EN, d);   check("R1 enable", d, 8'h00);
    check("R1 summary", {7'b0, errSummary}, 8'h00);
  endtask

  task automatic test_set_layout();
    logic [7:0] d;
    clean();
    pulse(8'h01 << 4);
    rd(A_STAT, d); check("R2 turnaround bit4", d, 8'h10);
    repeat (3) @(negedge clk);
    rd(A_STAT, d); check("R2 sticky", d, 8'h10);
    clean();
    pulse(8'h40);
    rd(A_STAT, d); check("R3 reserved event ignored", d, 8'h00);
    pulse(8'h80);
    rd(A_STAT, d); check("R3 bit-stuff bit7", d, 8'h80);
  endtask

  task automatic test_multi();
    logic [7:0] d;
    clean();
    pulse(8'hFF);
    rd(A_STAT, d); check("R9 all live bits", d, 8'hBF);
  endtask

  task automatic test_w1c();
    logic [7:0] d;
    clean();
    pulse(8'h2D);
    wr(A_STAT, 8'h05);
    rd(A_STAT, d); check("R4 clear ones only", d, 8'h28);
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); check("R4 zero write keeps", d, 8'h28);
  endtask

  task automatic test_collision();
    logic [7:0] d;
    clean();
    pulse(8'h06);
    @(negedge clk);
    busAddr = A_STAT; busWrEn = 1'b1; busWrData = 8'h06; errEvent = 8'h02;
    @(negedge clk);
    busWrEn = 1'b0; errEvent = '0;
    rd(A_STAT, d); check("R5 set beats clear", d, 8'h02);
  endtask

  task automatic test_enable();
    logic [7:0] d;
    clean();
    wr(A_EN, 8'hFF);
    rd(A_EN, d); check("R6 enable readback", d, 8'hBF);
    pulse(8'h08);
    rd(A_STAT, d); check("R11 enable write kept status", d, 8'h08);
    wr(A_STAT, 8'h08);
    rd(A_EN, d); check("R11 status write kept enable", d, 8'hBF);
  endtask

  task automatic test_summary();
    logic [7:0] d;
    clean();
    wr(A_EN, 8'h01);
    pulse(8'h04);
    @(negedge clk);
    check("R7 masked bit no summary", {7'b0, errSummary}, 8'h00);
    rd(A_STAT, d); check("R8 status ignores enable", d, 8'h04);
    @(negedge clk);
    errEvent = 8'h01;
    @(negedge clk);
    errEvent = '0;
    check("R7 summary not yet", {7'b0, errSummary}, 8'h00);
    @(negedge clk);
    check("R7 summary one cycle later", {7'b0, errSummary}, 8'h01);
    wr(A_STAT, 8'h01);
    @(negedge clk);
    check("R7 summary drops after clear", {7'b0, errSummary}, 8'h00);
  endtask

  task automatic test_unmapped();
    logic [7:0] d;
    clean();
    pulse(8'h20);
    wr(A_EN, 8'h20);
    wr(A_NONE, 8'hFF);
    rd(A_NONE, d); check("R10 unmapped reads zero", d, 8'h00);
    rd(A_STAT, d); check("R10 status untouched", d, 8'h20);
    rd(A_EN, d);   check("R10 enable untouched", d, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    test_set_layout();
    test_multi();
    test_w1c();
    test_collision();
    test_enable();
    test_summary();
    test_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule